// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off state of every switch in a crosspoint matrix of 8 columns by 16 rows, 128 cells in all. A controller presents a 4-bit row code, a 3-bit column code and a data bit. It then raises chip select and strobe. On each rising clock edge that samples both of them high, the addressed cell takes the data bit. The cell therefore follows the data input for as long as the write is enabled. It keeps the last value taken once the strobe drops.

The row code does not select rows in ascending order: two blocks of codes are swapped, as described under R2. A synchronous active-high reset clears the whole array whatever the other controls are doing, and it wins over a write in the same cycle. The full state leaves the block as a flat vector. A single read-back bit gives the state of the cell that the current address points at.

Top module: `xpt_switch_mem`

## Requirements
- R1: The state vector `sw_state` has 128 bits; the cell for physical column c (0..7) and physical row r (0..15) sits at bit index c*16 + r.
- R2: Row codes map to physical rows as follows. Codes 0..5 select rows 0..5. Codes 6 and 7 select rows 12 and 13. Codes 8..13 select rows 6..11. Codes 14 and 15 select rows 14 and 15.
- R3: The column code selects the physical column of the same number, with bit 0 of each code field as its least significant bit.
- R4: A cell is written only on a rising clock edge that samples both `cs` and `strobe` high with `rst` low; if either is low, no cell changes.
- R5: While the write stays enabled across several edges, the addressed cell takes `data` at each of them. After `strobe` is sampled low, the cell holds the value taken at the last enabled edge.
- R6: A write changes only the addressed cell; all other 127 cells keep their state.
- R7: Writing `data` = 1 turns the addressed switch on (bit = 1); writing 0 turns it off (bit = 0).
- R8: An edge that samples `rst` high clears all 128 cells, whatever the values of `cs` and `strobe`.
- R9: When `rst` and an enabled write are sampled at the same edge, the array ends all zero.
- R10: `rd_state` gives, with no clock delay, the state of the cell that the current `row_code` and `col_code` select after the row mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the whole array |
| cs | input | 1 | Chip select, active high |
| strobe | input | 1 | Write strobe, active high |
| data | input | 1 | Value written to the addressed cell |
| row_code | input | 4 | Row address code (mapped, see R2) |
| col_code | input | 3 | Column address code |
| sw_state | output | 128 | State of every switch, index col*16 + row |
| rd_state | output | 1 | State of the currently addressed cell |

## Verification
A wrong row mapping or a stray enable shows on `sw_state` one clock after the faulty write. The affected bit lands on a position that a per-write comparison of the full vector exposes. A reset path that ignores select, or that loses to a write, leaves bits set in the edge that follows the reset. A bad read-back selection shows combinationally on `rd_state` once the written cell and the selected cell differ.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Matrix geometry (the scrambled row map below assumes 16 rows)
    localparam int XPT_COLS  = 8;
    localparam int XPT_ROWS  = 16;
    localparam int XPT_COL_W = $clog2(XPT_COLS);
    localparam int XPT_ROW_W = $clog2(XPT_ROWS);
    localparam int XPT_CELLS = XPT_COLS * XPT_ROWS;
    localparam int XPT_IDX_W = $clog2(XPT_CELLS);

    // One sampled write request
    typedef struct packed {
        logic                 en;
        logic [XPT_ROW_W-1:0] row;
        logic [XPT_COL_W-1:0] col;
        logic                 data;
    } xpt_wr_req_t;

    // Map a row code to its physical row (R2)
    function automatic logic [XPT_ROW_W-1:0] xpt_phys_row(input logic [XPT_ROW_W-1:0] code);
        logic [XPT_ROW_W-1:0] r;
        if (code < XPT_ROW_W'(6))
            r = code;
        else if (code < XPT_ROW_W'(8))
            r = code + XPT_ROW_W'(6);
        else if (code < XPT_ROW_W'(14))
            r = code - XPT_ROW_W'(2);
        else
            r = code;
        return r;
    endfunction

    // Flat cell index from physical column and row (R1)
    function automatic logic [XPT_IDX_W-1:0] xpt_cell_idx(input logic [XPT_COL_W-1:0] col,
                                                          input logic [XPT_ROW_W-1:0] row);
        return {col, row};
    endfunction

endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode
    import xpt_pkg::*;
#(
    parameter int COLS  = XPT_COLS,
    parameter int ROWS  = XPT_ROWS,
    localparam int CELLS = COLS * ROWS
) (
    input  xpt_wr_req_t          req,
    output logic [XPT_ROW_W-1:0] prow,
    output logic [CELLS-1:0]     wen
);

    assign prow = xpt_phys_row(req.row);

    // One enable per cell: address match AND request enable (R4, R6)
    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign wen[c*ROWS + r] = req.en
                                   && (req.col == XPT_COL_W'(c))
                                   && (prow == XPT_ROW_W'(r));
        end
    end

endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
    parameter int CELLS = xpt_pkg::XPT_CELLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CELLS-1:0] wen,
    input  logic             din,
    output logic [CELLS-1:0] q
);

    // Each cell: sync clear wins, then enabled load (R5, R7, R8, R9)
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (wen[i])
                q[i] <= din;
        end
    end

endmodule

// File: rtl/xpt_switch_mem.sv
module xpt_switch_mem
    import xpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 strobe,
    input  logic                 data,
    input  logic [XPT_ROW_W-1:0] row_code,
    input  logic [XPT_COL_W-1:0] col_code,
    output logic [XPT_CELLS-1:0] sw_state,
    output logic                 rd_state
);

    xpt_wr_req_t          req;
    logic [XPT_ROW_W-1:0] prow;
    logic [XPT_CELLS-1:0] wen;

    always_comb begin
        req.en   = cs && strobe && !rst;
        req.row  = row_code;
        req.col  = col_code;
        req.data = data;
    end

    xpt_addr_decode #(
        .COLS (XPT_COLS),
        .ROWS (XPT_ROWS)
    ) u_dec (
        .req  (req),
        .prow (prow),
        .wen  (wen)
    );

    xpt_cell_array #(
        .CELLS (XPT_CELLS)
    ) u_cells (
        .clk (clk),
        .rst (rst),
        .wen (wen),
        .din (req.data),
        .q   (sw_state)
    );

    // Read-back of the addressed cell (R10)
    assign rd_state = sw_state[xpt_cell_idx(col_code, prow)];

endmodule

// File: rtl/xpt_switch_mem_chk.sv
module xpt_switch_mem_chk
    import xpt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cs,
    input logic                 strobe,
    input logic                 data,
    input logic [XPT_ROW_W-1:0] row_code,
    input logic [XPT_COL_W-1:0] col_code,
    input logic [XPT_CELLS-1:0] sw_state,
    input logic                 rd_state,
    input logic [XPT_CELLS-1:0] wen
);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R4: no enable without both select and strobe
    a_r4_enable_gated: assert property (@(posedge clk) disable iff (rst)
        !(cs && strobe) |-> (wen == '0));

    // R6: at most one cell targeted
    a_r6_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wen));

    // R6: cells outside the previous enable keep their state
    a_r6_others_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((sw_state ^ $past(sw_state)) & ~$past(wen)) == '0));

    // R5, R10: enabled write shows on the read-back if the address held
    a_r5_data_taken: assert property (@(posedge clk) disable iff (rst)
        (cs && strobe) |=> (!$stable(row_code) || !$stable(col_code)
                            || (rd_state == $past(data))));

    // R8, R9: one edge after reset the array is empty
    a_r8_reset_clears: assert property (@(posedge clk)
        rst_q |-> (sw_state == '0));

endmodule

bind xpt_switch_mem xpt_switch_mem_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .strobe   (strobe),
    .data     (data),
    .row_code (row_code),
    .col_code (col_code),
    .sw_state (sw_state),
    .rd_state (rd_state),
    .wen      (wen)
);

// File: tb/xpt_switch_mem_tb.sv
module xpt_switch_mem_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs = 1'b0;
    logic         strobe = 1'b0;
    logic         data = 1'b0;
    logic [3:0]   row_code = '0;
    logic [2:0]   col_code = '0;
    logic [127:0] sw_state;
    logic         rd_state;

    logic [127:0] exp_vec = '0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xpt_switch_mem u_dut (
        .clk      (clk),
        .rst      (rst),
        .cs       (cs),
        .strobe   (strobe),
        .data     (data),
        .row_code (row_code),
        .col_code (col_code),
        .sw_state (sw_state),
        .rd_state (rd_state)
    );

    // R2 mapping computed arithmetically
    function automatic int phys(int code);
        if (code >= 6 && code <= 7) return code + 6;
        if (code >= 8 && code <= 13) return code - 2;
        return code;
    endfunction

    function automatic int bit_of(int col, int code);
        return col * 16 + phys(code);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_vec(string req);
        n_chk++;
        if (sw_state !== exp_vec) begin
            n_bad++;
            $display("FAIL %s sw_state actual=%h expected=%h", req, sw_state, exp_vec);
        end
    endtask

    task automatic chk_rd(string req, logic e);
        n_chk++;
        if (rd_state !== e) begin
            n_bad++;
            $display("FAIL %s rd_state actual=%b expected=%b", req, rd_state, e);
        end
    endtask

    // One strobed write of a single clock; ends with strobe/cs low
    task automatic wr(int code, int col, logic d);
        row_code = 4'(code);
        col_code = 3'(col);
        data = d;
        cs = 1'b1;
        strobe = 1'b1;
        tick();
        strobe = 1'b0;
        cs = 1'b0;
        exp_vec[bit_of(col, code)] = d;
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        exp_vec = '0;
        chk_vec("R8 reset state");
        rst = 1'b0;

        // R2, R1: explicit scrambled positions
        wr(6, 2, 1'b1);
        n_chk++;
        if (sw_state !== (128'b1 << 44)) begin
            n_bad++; $display("FAIL R2 code6 col2 actual=%h expected=%h", sw_state, 128'b1 << 44);
        end
        wr(6, 2, 1'b0);
        wr(8, 0, 1'b1);
        n_chk++;
        if (sw_state !== (128'b1 << 6)) begin
            n_bad++; $display("FAIL R2 code8 col0 actual=%h expected=%h", sw_state, 128'b1 << 6);
        end
        wr(8, 0, 1'b0);
        chk_vec("R7 turn off");

        // R1 R2 R3 R7 R10: sweep on every address
        for (int a = 0; a < 128; a++) begin
            wr(a % 16, a / 16, 1'b1);
            chk_vec("R3 sweep on");
            chk_rd("R10 sweep on", 1'b1);
        end
        // R6 R7: turn off every other code
        for (int a = 0; a < 128; a += 2) begin
            wr(a % 16, a / 16, 1'b0);
            chk_vec("R6 sweep off");
            chk_rd("R10 sweep off", 1'b0);
        end
        // R10: read-back across all addresses without writing
        for (int a = 0; a < 128; a++) begin
            row_code = 4'(a % 16);
            col_code = 3'(a / 16);
            #1;
            chk_rd("R10 readback", exp_vec[bit_of(a / 16, a % 16)]);
        end

        // R4: select low or strobe low blocks writes
        row_code = 4'd0; col_code = 3'd0; data = 1'b1;
        cs = 1'b0; strobe = 1'b1;
        tick();
        chk_vec("R4 cs low");
        cs = 1'b1; strobe = 1'b0;
        tick();
        chk_vec("R4 strobe low");
        cs = 1'b0;

        // R5: transparency while enabled, hold after strobe falls
        row_code = 4'd9; col_code = 3'd5; cs = 1'b1; strobe = 1'b1;
        data = 1'b0;
        tick(); exp_vec[bit_of(5, 9)] = 1'b0; chk_vec("R5 follow 0");
        data = 1'b1;
        tick(); exp_vec[bit_of(5, 9)] = 1'b1; chk_vec("R5 follow 1");
        data = 1'b0;
        tick(); exp_vec[bit_of(5, 9)] = 1'b0; chk_vec("R5 follow 0 again");
        data = 1'b1;
        tick(); exp_vec[bit_of(5, 9)] = 1'b1;
        strobe = 1'b0; data = 1'b0;
        tick(); chk_vec("R5 hold after strobe");
        tick(); chk_rd("R5 hold readback", 1'b1);
        cs = 1'b0;

        // R8: reset with select low clears everything
        rst = 1'b1; strobe = 1'b1;
        tick();
        exp_vec = '0;
        chk_vec("R8 reset cs low");
        rst = 1'b0; strobe = 1'b0;

        // R9: reset and write in the same cycle
        wr(3, 1, 1'b1);
        rst = 1'b1; cs = 1'b1; strobe = 1'b1; data = 1'b1;
        row_code = 4'd4; col_code = 3'd7;
        tick();
        exp_vec = '0;
        chk_vec("R9 reset beats write");
        rst = 1'b0; cs = 1'b0; strobe = 1'b0;
        tick();
        chk_vec("R9 still clear");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule